// File: doc/BRIEF.md
# Partitioned Subword SIMD Adder

This block is one wide adder that can be treated as a single full-width lane or split at run time into several independent narrower lanes. A two-bit mode input chooses the element width. The carry chain is cut at every element boundary of that width, so no element can disturb its neighbours. The same operation applies to every element in the same cycle. It can add or subtract, and for either operation it can wrap around modulo the element width or clamp to the unsigned range.

The datapath width is a parameter. It must be a multiple of 64. The default is 128 bits, and 64 bits is also a supported configuration. The whole word passes through one register stage, and a valid flag travels alongside it. A result word appears exactly one clock after its operands are accepted.

Top module: `simd_part_adder`

## Requirements
- R1: The mode selects the element width: 2'b00 gives 8-bit elements, 2'b01 gives 16-bit, 2'b10 gives 32-bit and 2'b11 gives 64-bit. Element k occupies bits [k*W+W-1 : k*W]. With op_sub=0 and sat_en=0, each element of the result is (a_k + b_k) mod 2^W.
- R2: No carry or borrow crosses an element boundary. Each result element depends only on the operand elements at the same position.
- R3: With op_sub=1 and sat_en=0, each result element is (a_k - b_k) mod 2^W. This is formed by inverting b and forcing a carry-in of 1 at the lowest bit of each element.
- R4: With sat_en=1 and op_sub=0, an element whose unsigned sum exceeds 2^W-1 becomes all ones. Other elements give their exact sum.
- R5: With sat_en=1 and op_sub=1, an element where b_k > a_k becomes zero. Other elements give their exact difference.
- R6: out_valid is high in the cycle after a cycle with in_valid high, and low in the cycle after a cycle with in_valid low. The latency is exactly one cycle.
- R7: When in_valid is low, the result register keeps its value, whatever the other inputs do.
- R8: A synchronous active-high reset clears out_valid and result to zero.
- R9: One operation and one width apply to every element of the word in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Operands valid; the result register loads |
| mode | input | 2 | Element width select (00=8, 01=16, 10=32, 11=64) |
| op_sub | input | 1 | 1 = subtract b from a, 0 = add |
| sat_en | input | 1 | 1 = unsigned saturation, 0 = wraparound |
| a | input | DATA_W | First operand word |
| b | input | DATA_W | Second operand word |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | DATA_W | Registered element-wise result |

## Verification
Clamping in one element and wraparound or an exact result in the next element can happen in the same cycle. This is where a leaking carry or a clamp applied to the wrong element would show. The stimulus places an overflowing element directly below one that holds all ones or zero. It does this for every width, for addition and subtraction, and with saturation both on and off. The whole result word is then compared with a per-element model that the bench computes from the mode, so a carry that leaks or a clamp that lands on the wrong element changes a neighbouring element and causes a mismatch.

// File: rtl/simd_add_pkg.sv
package simd_add_pkg;
  typedef enum logic [1:0] {
    ELEM_8  = 2'b00,
    ELEM_16 = 2'b01,
    ELEM_32 = 2'b10,
    ELEM_64 = 2'b11
  } elem_mode_e;

  localparam int unsigned SLICE_W = 8;

  // Number of byte slices per element, minus one.
  function automatic logic [2:0] span_minus1(input elem_mode_e m);
    case (m)
      ELEM_8:  span_minus1 = 3'd0;
      ELEM_16: span_minus1 = 3'd1;
      ELEM_32: span_minus1 = 3'd3;
      default: span_minus1 = 3'd7;
    endcase
  endfunction
endpackage

// File: rtl/simd_seg_ctrl.sv
module simd_seg_ctrl
  import simd_add_pkg::*;
#(
  parameter int unsigned NSLICE = 16
) (
  input  elem_mode_e        mode,
  input  logic [NSLICE-1:0] slice_cout,
  output logic [NSLICE-1:0] seg_start,
  output logic [NSLICE-1:0] elem_cout
);
  localparam int unsigned IDX_W = (NSLICE > 8) ? $clog2(NSLICE) : 3;

  logic [IDX_W-1:0] span_m1;
  assign span_m1 = IDX_W'(span_minus1(mode));

  for (genvar i = 0; i < NSLICE; i++) begin : g_slice
    logic [IDX_W-1:0] top_idx;
    assign seg_start[i] = ((IDX_W'(i) & span_m1) == '0);
    assign top_idx      = IDX_W'(i) | span_m1;
    assign elem_cout[i] = slice_cout[top_idx];
  end
endmodule

// File: rtl/simd_byte_adder.sv
module simd_byte_adder #(
  parameter int unsigned W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         sub,
  input  logic         seg_start,
  input  logic         carry_prev,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W-1:0] b_eff;
  logic         cin;

  assign b_eff = sub ? ~b : b;
  assign cin   = seg_start ? sub : carry_prev;
  assign {cout, sum} = {1'b0, a} + {1'b0, b_eff} + {{W{1'b0}}, cin};
endmodule

// File: rtl/simd_sat_clamp.sv
module simd_sat_clamp #(
  parameter int unsigned NSLICE = 16,
  parameter int unsigned SW     = 8
) (
  input  logic [NSLICE*SW-1:0] raw,
  input  logic [NSLICE-1:0]    elem_cout,
  input  logic                 sub,
  input  logic                 sat_en,
  output logic [NSLICE*SW-1:0] clamped
);
  for (genvar i = 0; i < NSLICE; i++) begin : g_clamp
    logic out_of_range;
    // Add: carry out of the element top means overflow.
    // Sub: no carry out of the element top means a borrow.
    assign out_of_range = sat_en & (sub ? ~elem_cout[i] : elem_cout[i]);
    assign clamped[i*SW +: SW] = out_of_range ? (sub ? {SW{1'b0}} : {SW{1'b1}})
                                              : raw[i*SW +: SW];
  end
endmodule

// File: rtl/simd_part_adder.sv
module simd_part_adder
  import simd_add_pkg::*;
#(
  parameter int unsigned DATA_W = 128
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic [1:0]        mode,
  input  logic              op_sub,
  input  logic              sat_en,
  input  logic [DATA_W-1:0] a,
  input  logic [DATA_W-1:0] b,
  output logic              out_valid,
  output logic [DATA_W-1:0] result
);
  localparam int unsigned NSLICE = DATA_W / SLICE_W;

  elem_mode_e        mode_e;
  logic [NSLICE-1:0] seg_start;
  logic [NSLICE-1:0] slice_cout;
  logic [NSLICE-1:0] elem_cout;
  logic [DATA_W-1:0] raw_sum;
  logic [DATA_W-1:0] next_result;

  assign mode_e = elem_mode_e'(mode);

  simd_seg_ctrl #(.NSLICE(NSLICE)) u_seg (
    .mode       (mode_e),
    .slice_cout (slice_cout),
    .seg_start  (seg_start),
    .elem_cout  (elem_cout)
  );

  for (genvar i = 0; i < NSLICE; i++) begin : g_add
    logic carry_prev;
    if (i == 0) begin : g_first
      assign carry_prev = 1'b0;
    end else begin : g_rest
      assign carry_prev = slice_cout[i-1];
    end
    simd_byte_adder #(.W(SLICE_W)) u_byte (
      .a          (a[i*SLICE_W +: SLICE_W]),
      .b          (b[i*SLICE_W +: SLICE_W]),
      .sub        (op_sub),
      .seg_start  (seg_start[i]),
      .carry_prev (carry_prev),
      .sum        (raw_sum[i*SLICE_W +: SLICE_W]),
      .cout       (slice_cout[i])
    );
  end

  simd_sat_clamp #(.NSLICE(NSLICE), .SW(SLICE_W)) u_clamp (
    .raw       (raw_sum),
    .elem_cout (elem_cout),
    .sub       (op_sub),
    .sat_en    (sat_en),
    .clamped   (next_result)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      result    <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) result <= next_result;
    end
  end
endmodule

// File: rtl/simd_part_adder_chk.sv
module simd_part_adder_chk #(
  parameter int unsigned DATA_W = 128
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic [1:0]        mode,
  input logic              op_sub,
  input logic              sat_en,
  input logic [7:0]        a0,
  input logic [7:0]        b0,
  input logic              out_valid,
  input logic [DATA_W-1:0] result
);
  p_reset_clear_r8: assert property (@(posedge clk)
    rst |=> (!out_valid && result == '0));

  p_valid_follow_r6: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> out_valid);

  p_idle_follow_r6: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !out_valid);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(result));

  p_wrap_byte_r1: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && !op_sub && !sat_en)
      |=> result[7:0] == $past(8'(a0 + b0)));

  p_sat_add_floor_r4: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && !op_sub && sat_en)
      |=> result[7:0] >= $past(a0));

  p_sat_sub_ceiling_r5: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && op_sub && sat_en)
      |=> result[7:0] <= $past(a0));
endmodule

bind simd_part_adder simd_part_adder_chk #(.DATA_W(DATA_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .mode      (mode),
  .op_sub    (op_sub),
  .sat_en    (sat_en),
  .a0        (a[7:0]),
  .b0        (b[7:0]),
  .out_valid (out_valid),
  .result    (result)
);

// File: tb/simd_part_adder_bench.sv
module simd_part_adder_bench;
  localparam int unsigned DATA_W = 128;
  localparam int unsigned NVEC   = 10;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              in_valid = 1'b0;
  logic [1:0]        mode = 2'b00;
  logic              op_sub = 1'b0;
  logic              sat_en = 1'b0;
  logic [DATA_W-1:0] a = '0;
  logic [DATA_W-1:0] b = '0;
  logic              out_valid;
  logic [DATA_W-1:0] result;

  int checks = 0;
  int failures = 0;

  always #10 clk = ~clk;

  simd_part_adder #(.DATA_W(DATA_W)) u_simd_part_adder (
    .clk(clk), .rst(rst), .in_valid(in_valid), .mode(mode),
    .op_sub(op_sub), .sat_en(sat_en), .a(a), .b(b),
    .out_valid(out_valid), .result(result)
  );

  localparam logic [DATA_W-1:0] TA [NVEC] = '{
    128'h00FF_FF01_8080_1234_5678_9ABC_DEF0_00FF,
    128'h00FF_FF01_8080_1234_5678_9ABC_DEF0_FFFF,
    128'h7FFF_FFFF_0000_0001_FFFF_FFFF_1234_5678,
    128'h0000_0000_0000_0000_FFFF_FFFF_FFFF_FFFF,
    128'h0010_0000_7F80_0102_0304_0506_0708_0000,
    128'h0010_0000_7F80_0102_0304_0506_0708_0000,
    128'hF0FF_0180_7F00_FFFE_0102_0304_0506_07FF,
    128'h0005_FFFF_0001_8000_1234_0000_FFFF_0003,
    128'hFFFF_FFF0_0000_0001_8000_0000_7FFF_FFFF,
    128'h0000_0000_0000_0005_FFFF_FFFF_FFFF_FFFF
  };
  localparam logic [DATA_W-1:0] TB [NVEC] = '{
    128'h0001_0001_8080_1111_2222_3333_4444_0001,
    128'h0001_0001_8080_1111_2222_3333_4444_0001,
    128'h0001_0001_FFFF_FFFF_0000_0001_1111_1111,
    128'h0000_0000_0000_0000_0000_0000_0000_0001,
    128'h0001_0001_8080_0201_0403_0605_0807_0001,
    128'h0001_0001_8080_0201_0403_0605_0807_0001,
    128'h2001_FF80_7F01_0002_0101_0101_0101_0101,
    128'h0006_0001_0002_8000_1235_0001_0000_0004,
    128'h0000_0010_FFFF_FFFF_8000_0000_0000_0001,
    128'h0000_0000_0000_0006_0000_0000_0000_0001
  };
  localparam logic [1:0] TM [NVEC] = '{2'b00, 2'b01, 2'b10, 2'b11, 2'b00,
                                       2'b01, 2'b00, 2'b01, 2'b10, 2'b11};
  localparam logic TS [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b1,
                                 1'b1, 1'b0, 1'b1, 1'b0, 1'b1};
  localparam logic TT [NVEC] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0,
                                 1'b0, 1'b1, 1'b1, 1'b1, 1'b1};

  // Element-wise reference built from the requirements.
  function automatic logic [DATA_W-1:0] model(input logic [DATA_W-1:0] ma,
      input logic [DATA_W-1:0] mb, input logic [1:0] mm, input logic msub,
      input logic msat);
    int w = 8 << mm;
    logic [64:0] mask = (65'd1 << w) - 65'd1;
    logic [DATA_W-1:0] res = '0;
    for (int e = 0; e < DATA_W / w; e++) begin
      logic [DATA_W-1:0] sa = ma >> (e * w);
      logic [DATA_W-1:0] sb = mb >> (e * w);
      logic [64:0] ea = {1'b0, sa[63:0]} & mask;
      logic [64:0] eb = {1'b0, sb[63:0]} & mask;
      logic [64:0] r = msub ? (ea - eb) : (ea + eb);
      logic ovf = msub ? (ea < eb) : r[w];
      r = r & mask;
      if (msat && ovf) r = msub ? 65'd0 : mask;
      res = res | ({64'd0, r[63:0]} << (e * w));
    end
    return res;
  endfunction

  task automatic check(input string req, input logic [DATA_W-1:0] got,
                       input logic [DATA_W-1:0] exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic apply(input logic [DATA_W-1:0] va, input logic [DATA_W-1:0] vb,
                       input logic [1:0] vm, input logic vs, input logic vt);
    @(negedge clk);
    a = va; b = vb; mode = vm; op_sub = vs; sat_en = vt; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
  endtask

  initial begin
    #(20 * 200000);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R8: reset state
    check("R8 out_valid", {{(DATA_W-1){1'b0}}, out_valid}, '0);
    check("R8 result", result, '0);
    rst = 1'b0;

    // Table walk: R1 add, R3 sub, R4/R5 saturation across all widths
    for (int i = 0; i < NVEC; i++) begin
      apply(TA[i], TB[i], TM[i], TS[i], TT[i]);
      check(TT[i] ? (TS[i] ? "R5 sat sub" : "R4 sat add")
                  : (TS[i] ? "R3 sub" : "R1 add"),
            result, model(TA[i], TB[i], TM[i], TS[i], TT[i]));
    end

    // R2: a carry out of the low element must not reach the next one
    apply(128'h00FF, 128'h0001, 2'b00, 1'b0, 1'b0);
    check("R2 byte boundary", result, 128'h0000);
    apply(128'h0000_FFFF, 128'h0001, 2'b01, 1'b0, 1'b0);
    check("R2 halfword boundary", result, 128'h0000_0000);
    apply(128'h0000_FFFF, 128'h0001, 2'b10, 1'b0, 1'b0);
    check("R2 word spans bytes", result, 128'h0001_0000);
    apply(128'h0, 128'h0001, 2'b00, 1'b1, 1'b0);
    check("R2 borrow boundary", result, 128'h0000_00FF);

    // R1: 64-bit elements, explicit values
    apply({64'd1, 64'hFFFF_FFFF_FFFF_FFFE}, {64'd2, 64'd1}, 2'b11, 1'b0, 1'b0);
    check("R1 64-bit", result, {64'd3, 64'hFFFF_FFFF_FFFF_FFFF});

    // R9: same operation on every element
    apply({4{32'h0000_0010}}, {4{32'h0000_0003}}, 2'b10, 1'b1, 1'b0);
    check("R9 uniform sub", result, {4{32'h0000_000D}});

    // R6: latency and valid tracking
    @(negedge clk);
    a = 128'h1; b = 128'h1; mode = 2'b00; op_sub = 1'b0; sat_en = 1'b0;
    in_valid = 1'b1;
    @(negedge clk);
    check("R6 valid after one cycle", {{(DATA_W-1){1'b0}}, out_valid}, 128'h1);
    check("R6 result after one cycle", result, 128'h2);
    in_valid = 1'b0;
    a = 128'h55; b = 128'h22;
    @(negedge clk);
    check("R6 valid drops", {{(DATA_W-1){1'b0}}, out_valid}, '0);
    // R7: held while idle, even with inputs changing
    check("R7 hold", result, 128'h2);
    mode = 2'b11; op_sub = 1'b1; sat_en = 1'b1;
    @(negedge clk);
    check("R7 hold after input change", result, 128'h2);

    // R8: reset after activity clears state
    rst = 1'b1;
    @(negedge clk);
    check("R8 reset clears result", result, '0);
    check("R8 reset clears valid", {{(DATA_W-1){1'b0}}, out_valid}, '0);
    rst = 1'b0;

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule